// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives one display backlight pin with a pulse-width-modulated waveform. A prescaler divides the input clock into ticks. A period counter then counts ticks, and the pin is high for a programmable number of ticks at the start of every period. Software sets the block up through a small synchronous register bus, which has an address, a write strobe, write data and registered read data.

The divider, period and high-width settings are first written into shadow registers. Writing the commit bit high and then low arms a transfer. That transfer copies all three shadow values into the working registers at the next period boundary, so a running period always finishes with its old settings. When the block is disabled, an armed transfer takes place at once. Setting both bits of the debug field turns off double buffering, and the working registers then follow the shadow registers directly.

Top module: `backlight_pwm`

## Requirements
- R1: After reset, `pwm_out` is low and every register reads back as zero.
- R2: One tick lasts (divider + 1) clock cycles, and one period lasts (period + 1) ticks, so the output repeats every (period + 1) × (divider + 1) cycles.
- R3: The output is high for the first high-width ticks of each period. A high width of zero keeps it low. A high width above the period value keeps it high for the whole period.
- R4: Bit 0 at offset 0x00 enables the block. While that bit is clear, `pwm_out` is low and both counters are held at zero, so the first period after enabling starts from tick zero.
- R5: With double buffering active, writes to the control words (offsets 0x10 and 0x14) do not change the output until a commit transfer occurs.
- R6: Writing bit 0 of offset 0x08 as 1 and then as 0 arms a transfer. While the block is enabled, the divider, period and high width all take effect together at the next period boundary.
- R7: When bits 1:0 at offset 0x80 are both 1, a control-word write reaches the working registers one cycle after the shadow register updates, and no commit is needed.
- R8: Read data appears one cycle after the address is presented. The fields are: divider at bits 25:16 of 0x10; period at bits 11:0 and high width at bits 28:16 of 0x14; enable at bit 0 of 0x00; commit at bit 0 of 0x08; debug at bits 1:0 of 0x80. Unused bits and unmapped offsets read as zero.
- R9: A transfer armed while the block is disabled is applied on the next cycle, so a later enable runs with the committed values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
A register write takes effect at the clock edge where it is sampled. `pwm_out` is decoded from the counter registers, so a change of enable or of the working settings appears right after that edge. Read data is valid one edge after the address. A commit first arms on the edge that samples the clearing write, and is then applied on the boundary edge. In bypass mode, the working registers change one edge after the shadow registers. The bench drives the bus on falling edges and runs a behavioural model on every rising edge. On each falling edge it compares the pin and the read data against that model, so every expected value is sampled exactly one edge after the stimulus that causes it.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int DATA_W_DEF = 32;
  localparam int DIV_W_DEF  = 10;
  localparam int PER_W_DEF  = 12;
  localparam int HIGH_W_DEF = 13;

  // field positions decoded by software
  localparam int DIV_LSB  = 16;
  localparam int PER_LSB  = 0;
  localparam int HIGH_LSB = 16;

  // register byte offsets
  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_COMMIT = 8'h08;
  localparam logic [7:0] OFS_CTL0   = 8'h10;
  localparam logic [7:0] OFS_CTL1   = 8'h14;
  localparam logic [7:0] OFS_DEBUG  = 8'h80;

  localparam logic [1:0] DBG_DIRECT = 2'b11;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int PER_W  = PER_W_DEF,
  parameter int HIGH_W = HIGH_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              boundary,
  output logic [DATA_W-1:0] rdata,
  output logic              enable,
  output logic              bypass,
  output logic              pending,
  output logic              apply,
  output logic [DIV_W-1:0]  div_w,
  output logic [PER_W-1:0]  per_w,
  output logic [HIGH_W-1:0] high_w
);
  logic              en_q, en_d, cmt_q, cmt_d, pend_q, pend_d;
  logic [1:0]        dbg_q, dbg_d;
  logic [DIV_W-1:0]  sdiv_q, sdiv_d, wdiv_q, wdiv_d;
  logic [PER_W-1:0]  sper_q, sper_d, wper_q, wper_d;
  logic [HIGH_W-1:0] shigh_q, shigh_d, whigh_q, whigh_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic hit_en, hit_cmt, hit_c0, hit_c1, hit_dbg, commit_fall;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign hit_en  = we && (addr == ADDR_W'(OFS_ENABLE));
  assign hit_cmt = we && (addr == ADDR_W'(OFS_COMMIT));
  assign hit_c0  = we && (addr == ADDR_W'(OFS_CTL0));
  assign hit_c1  = we && (addr == ADDR_W'(OFS_CTL1));
  assign hit_dbg = we && (addr == ADDR_W'(OFS_DEBUG));

  assign commit_fall = hit_cmt && cmt_q && !wdata[0];
  assign bypass      = (dbg_q == DBG_DIRECT);
  assign apply       = bypass || (pend_q && (boundary || !en_q));

  always_comb begin
    en_d    = hit_en  ? wdata[0]   : en_q;
    cmt_d   = hit_cmt ? wdata[0]   : cmt_q;
    dbg_d   = hit_dbg ? wdata[1:0] : dbg_q;
    sdiv_d  = hit_c0  ? wdata[DIV_LSB +: DIV_W]   : sdiv_q;
    sper_d  = hit_c1  ? wdata[PER_LSB +: PER_W]   : sper_q;
    shigh_d = hit_c1  ? wdata[HIGH_LSB +: HIGH_W] : shigh_q;
    pend_d  = commit_fall || (pend_q && !apply);
    wdiv_d  = apply ? sdiv_q  : wdiv_q;
    wper_d  = apply ? sper_q  : wper_q;
    whigh_d = apply ? shigh_q : whigh_q;
  end

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(OFS_ENABLE)) rd_d[0] = en_q;
    if (addr == ADDR_W'(OFS_COMMIT)) rd_d[0] = cmt_q;
    if (addr == ADDR_W'(OFS_DEBUG))  rd_d[1:0] = dbg_q;
    if (addr == ADDR_W'(OFS_CTL0))   rd_d[DIV_LSB +: DIV_W] = sdiv_q;
    if (addr == ADDR_W'(OFS_CTL1)) begin
      rd_d[PER_LSB +: PER_W]   = sper_q;
      rd_d[HIGH_LSB +: HIGH_W] = shigh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; cmt_q <= 1'b0; pend_q <= 1'b0; dbg_q <= '0;
      sdiv_q <= '0; sper_q <= '0; shigh_q <= '0;
      wdiv_q <= '0; wper_q <= '0; whigh_q <= '0;
      rd_q <= '0;
    end else begin
      en_q <= en_d; cmt_q <= cmt_d; pend_q <= pend_d; dbg_q <= dbg_d;
      sdiv_q <= sdiv_d; sper_q <= sper_d; shigh_q <= shigh_d;
      wdiv_q <= wdiv_d; wper_q <= wper_d; whigh_q <= whigh_d;
      rd_q <= rd_d;
    end
  end

  assign rdata   = rd_q;
  assign enable  = en_q;
  assign pending = pend_q;
  assign div_w   = wdiv_q;
  assign per_w   = wper_q;
  assign high_w  = whigh_q;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_w,
  input  logic [PER_W-1:0]  per_w,
  input  logic [HIGH_W-1:0] high_w,
  output logic              boundary,
  output logic [DIV_W-1:0]  tick_cnt,
  output logic [PER_W-1:0]  per_cnt,
  output logic              pwm_out
);
  localparam int CMP_W = ((HIGH_W > PER_W) ? HIGH_W : PER_W) + 1;

  logic [DIV_W-1:0] tick_q, tick_d;
  logic [PER_W-1:0] per_q, per_d;
  logic tick_wrap, per_wrap;

  assign tick_wrap = (tick_q >= div_w);
  assign per_wrap  = (per_q >= per_w);
  assign boundary  = enable && tick_wrap && per_wrap;

  always_comb begin
    tick_d = tick_q;
    per_d  = per_q;
    if (!enable) begin
      tick_d = '0;
      per_d  = '0;
    end else if (tick_wrap) begin
      tick_d = '0;
      per_d  = per_wrap ? '0 : per_q + 1'b1;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      per_q  <= '0;
    end else begin
      tick_q <= tick_d;
      per_q  <= per_d;
    end
  end

  assign pwm_out  = enable && (CMP_W'(per_q) < CMP_W'(high_w));
  assign tick_cnt = tick_q;
  assign per_cnt  = per_q;
endmodule

// File: rtl/backlight_pwm.sv
module backlight_pwm
  import bl_pwm_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEF,
  parameter int PER_W  = PER_W_DEF,
  parameter int HIGH_W = HIGH_W_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out
);
  logic              enable, bypass, pending, apply, boundary;
  logic [DIV_W-1:0]  div_w, tick_cnt;
  logic [PER_W-1:0]  per_w, per_cnt;
  logic [HIGH_W-1:0] high_w;

  bl_pwm_regs #(
    .ADDR_W(8), .DATA_W(32), .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .boundary(boundary), .rdata(bus_rdata), .enable(enable), .bypass(bypass),
    .pending(pending), .apply(apply), .div_w(div_w), .per_w(per_w), .high_w(high_w)
  );

  bl_pwm_core #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_w(div_w), .per_w(per_w),
    .high_w(high_w), .boundary(boundary), .tick_cnt(tick_cnt), .per_cnt(per_cnt),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              bypass,
  input logic              pending,
  input logic              apply,
  input logic              boundary,
  input logic [DIV_W-1:0]  div_w,
  input logic [PER_W-1:0]  per_w,
  input logic [HIGH_W-1:0] high_w,
  input logic [DIV_W-1:0]  tick_cnt,
  input logic [PER_W-1:0]  per_cnt
);
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (tick_cnt == '0 && per_cnt == '0)); // R4

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick_cnt < div_w) |=> (tick_cnt == $past(tick_cnt) + 1'b1)); // R2

  AST_HOLD_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(div_w) && $stable(per_w) && $stable(high_w))); // R5

  AST_WAIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && enable && !bypass && !boundary) |=> pending); // R6
endmodule

bind backlight_pwm bl_pwm_chk #(
  .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .bypass(bypass), .pending(pending),
  .apply(apply), .boundary(boundary), .div_w(div_w), .per_w(per_w),
  .high_w(high_w), .tick_cnt(tick_cnt), .per_cnt(per_cnt)
);

// File: tb/test_backlight_pwm.sv
module test_backlight_pwm;
  logic        clk, rst_n, we, pwm;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  int checks = 0, failures = 0;
  bit live = 0, done = 0;
  string tag = "R2 R3";

  // behavioural reference state
  int m_en, m_cmt, m_dbg, s_div, s_per, s_high, w_div, w_per, w_high, pend, tc, pc;
  int ntc, npc;
  bit bnd, app, cf;
  logic [31:0] m_rd;

  backlight_pwm i_backlight_pwm (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pwm_out(pwm)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v = m_en;
      8'h08: v = m_cmt;
      8'h10: v = s_div << 16;
      8'h14: v = (s_high << 16) | s_per;
      8'h80: v = m_dbg;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_cmt = 0; m_dbg = 0; s_div = 0; s_per = 0; s_high = 0;
      w_div = 0; w_per = 0; w_high = 0; pend = 0; tc = 0; pc = 0; m_rd = '0;
    end else begin
      m_rd = ref_read(addr);
      bnd = (m_en != 0) && tc >= w_div && pc >= w_per;
      app = (m_dbg == 3) || (pend != 0 && (bnd || m_en == 0));
      cf  = we && addr == 8'h08 && m_cmt == 1 && wdata[0] == 0;
      if (m_en == 0) begin ntc = 0; npc = 0; end
      else if (tc >= w_div) begin ntc = 0; npc = (pc >= w_per) ? 0 : pc + 1; end
      else begin ntc = tc + 1; npc = pc; end
      if (app) begin w_div = s_div; w_per = s_per; w_high = s_high; end
      pend = (cf || (pend != 0 && !app)) ? 1 : 0;
      if (we) begin
        case (addr)
          8'h00: m_en = wdata[0];
          8'h08: m_cmt = wdata[0];
          8'h10: s_div = wdata[25:16];
          8'h14: begin s_per = wdata[11:0]; s_high = wdata[28:16]; end
          8'h80: m_dbg = wdata[1:0];
          default: ;
        endcase
      end
      tc = ntc; pc = npc;
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk(tag, {31'b0, pwm}, {31'b0, (m_en != 0) && (pc < w_high)});
      chk("R8 rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0; addr = 8'h40; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 0;
    @(negedge clk); v = rdata; addr = 8'h40;
  endtask

  task automatic commit();
    wr(8'h08, 1); wr(8'h08, 0);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm) h++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int h;
    rst_n = 0; we = 0; addr = 8'h40; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    // R1: reset state
    chk("R1 pwm", {31'b0, pwm}, 0);
    rd(8'h00, v); chk("R1 enable", v, 0);
    rd(8'h08, v); chk("R1 commit", v, 0);
    rd(8'h10, v); chk("R1 ctl0", v, 0);
    rd(8'h14, v); chk("R1 ctl1", v, 0);
    rd(8'h80, v); chk("R1 debug", v, 0);

    // divider 1, period 4, high 2: 10-cycle period, 4 high
    wr(8'h10, 32'd1 << 16);
    wr(8'h14, (32'd2 << 16) | 32'd4);
    rd(8'h10, v); chk("R8 ctl0 readback", v, 32'h0001_0000);
    rd(8'h14, v); chk("R8 ctl1 readback", v, 32'h0002_0004);
    tag = "R9";
    commit();
    tag = "R4";
    wr(8'h00, 1);
    count_high(10, h); chk("R3 R9 high cycles", h, 4);
    chk("R2 new period starts high", {31'b0, pwm}, 1);
    tag = "R2 R3";
    count_high(20, h); chk("R2 two periods", h, 8);

    // shadow write without commit
    tag = "R5";
    wr(8'h14, (32'd5 << 16) | 32'd4);
    repeat (25) @(negedge clk);
    count_high(10, h); chk("R5 no effect before commit", h, 4);

    // commit: applied at period boundary
    tag = "R6";
    commit();
    repeat (12) @(negedge clk);
    count_high(10, h); chk("R6 R3 full-high after commit", h, 10);
    rd(8'h14, v); chk("R8 ctl1 readback", v, 32'h0005_0004);

    // high width zero
    tag = "R3";
    wr(8'h14, 32'd4);
    commit();
    repeat (12) @(negedge clk);
    count_high(10, h); chk("R3 zero width low", h, 0);

    // debug bypass
    tag = "R7";
    wr(8'h80, 3);
    rd(8'h80, v); chk("R8 debug readback", v, 3);
    wr(8'h14, (32'd1 << 16) | 32'd2);
    repeat (14) @(negedge clk);
    count_high(6, h); chk("R7 direct update", h, 2);

    // disable and re-enable
    tag = "R4";
    wr(8'h00, 0);
    chk("R4 low on disable", {31'b0, pwm}, 0);
    count_high(20, h); chk("R4 low while disabled", h, 0);
    wr(8'h00, 1);
    chk("R4 restart high", {31'b0, pwm}, 1);
    count_high(6, h); chk("R4 first period clean", h, 2);

    rd(8'h40, v); chk("R8 unmapped reads zero", v, 0);
    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule